// File: doc/BRIEF.md
# Clock Output Enable Gate

This block passes a free-running raw clock to an output pin only while an active-high enable input asks for it. When the enable is removed, the output stops in one of four ways, chosen by a static two-bit stop-mode input. The output can drop at once. It can finish the high phase it is in. It can run out a fixed number of extra cycles. Or it can release the pin to a high-impedance state so that several sources can share one clock line.

Every wake-up inserts a hold-low settling window before the first period reaches the pin. This applies after reset release and after the enable returns high. The first period that does reach the pin is always complete. The enable is brought into the raw-clock domain through a two-flop synchroniser. Gating is done by an enable register that updates on the falling edge of the raw clock, so the gate only changes while the clock is low. The immediate stop mode is the one exception: it clears that register asynchronously from the raw enable.

Top module: `clkout_gate`

## Requirements
- R1: While the block is running (enable high and settling done), `clk_o` follows `clk_i` with full-width high phases on every raw cycle.
- R2: In stop mode 2'b00 (immediate), `clk_o` goes low as soon as `en_i` falls, even within a high phase, and no pulse follows.
- R3: In stop mode 2'b01 (finish), a high phase in progress when `en_i` falls completes at full width. Exactly 3 full pulses are seen from the first raw rising edge after the fall: two synchroniser cycles plus the period in which the fall is detected.
- R4: In stop mode 2'b10 (run-out), exactly DRAIN_CYC more full pulses follow the 3 of R3. With the default of 32, that makes 35 pulses.
- R5: In stop mode 2'b11 (float), `oe_o` is low whenever the block is disabled, and `clk_o` stops as in R3. `oe_o` is high in every other mode and state, and rises again once a wake-up is detected.
- R6: After reset release with `en_i` high, or after `en_i` rises, `clk_o` stays low. Its first rising edge falls on raw rising edge number SETTLE_CYC+4 (7 by default), counted from the first edge after the stimulus.
- R7: If `en_i` returns high during a run-out, the output continues without a gap and without a new settling window.
- R8: The stop mode is captured only while the block is disabled. A change of `mode_i` while running has no effect on the next stop.
- R9: While `rst_ni` is low, `clk_o` is low and `oe_o` is high. Asserting reset in the middle of a high phase drops `clk_o` at once.
- R10: Once a stop sequence has finished, `clk_o` stays low for as long as the enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Raw free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Active-high output enable, asynchronous to clk_i |
| mode_i | input | 2 | Stop mode: 00 immediate, 01 finish, 10 run-out, 11 float |
| clk_o | output | 1 | Gated clock output |
| oe_o | output | 1 | Pad output-enable, low only when disabled in float mode |

## Verification
The hardest case to reach is an enable that comes back during a run-out. The bench must drop the enable and then raise it again within the 32-cycle window, after the synchroniser has let the drop through but before the count ends. It does this by counting raw cycles from a negedge-aligned drop, and then checks that the pulse total over the whole window equals the number of raw cycles. A second hard case is a mode change made while running. The bench changes `mode_i` after the stop mode has already been captured and then drops the enable in the middle of a high phase. Whether the output falls or holds at that moment shows which mode the block obeyed.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;
  typedef enum logic [1:0] {
    STOP_NOW    = 2'b00,
    STOP_FINISH = 2'b01,
    STOP_DRAIN  = 2'b10,
    STOP_FLOAT  = 2'b11
  } stop_mode_e;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_SETTLE,
    ST_RUN,
    ST_DRAIN
  } gate_state_e;
endpackage

// File: rtl/clkout_gate_sync.sv
module clkout_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkout_gate_pkg::*;
#(
  parameter int SETTLE_CYC = 3,
  parameter int DRAIN_CYC  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_s_i,
  input  logic        en_raw_i,
  input  logic [1:0]  mode_i,
  output logic        run_req_o,
  output logic        oe_o,
  output logic        kill_o,
  output logic        settling_o,
  output logic        draining_o,
  output logic        off_o,
  output logic [1:0]  mode_q_o
);
  localparam int CNT_MAX = (SETTLE_CYC > DRAIN_CYC) ? SETTLE_CYC : DRAIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] DRAIN_LAST  = CNT_W'(DRAIN_CYC - 1);

  gate_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  stop_mode_e       mode_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_OFF: begin
        if (en_s_i) begin
          state_d = ST_SETTLE;
          cnt_d   = '0;
        end
      end
      ST_SETTLE: begin
        if (!en_s_i)                   state_d = ST_OFF;
        else if (cnt_q == SETTLE_LAST) state_d = ST_RUN;
        else                           cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_RUN: begin
        if (!en_s_i) begin
          if (mode_q == STOP_DRAIN) begin
            state_d = ST_DRAIN;
            cnt_d   = '0;
          end else begin
            state_d = ST_OFF;
          end
        end
      end
      ST_DRAIN: begin
        // re-enable abandons the run-out, no new settling
        if (en_s_i)                   state_d = ST_RUN;
        else if (cnt_q == DRAIN_LAST) state_d = ST_OFF;
        else                          cnt_d   = cnt_q + CNT_W'(1);
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      mode_q  <= STOP_NOW;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_OFF) mode_q <= stop_mode_e'(mode_i);
    end
  end

  assign run_req_o  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
  assign oe_o       = !((state_q == ST_OFF) && (mode_q == STOP_FLOAT));
  assign kill_o     = !en_raw_i && (mode_q == STOP_NOW);
  assign settling_o = (state_q == ST_SETTLE);
  assign draining_o = (state_q == ST_DRAIN);
  assign off_o      = (state_q == ST_OFF);
  assign mode_q_o   = mode_q;
endmodule

// File: rtl/clkout_gate_cell.sv
module clkout_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kill_i,
  input  logic req_i,
  output logic gate_q_o,
  output logic clk_o
);
  logic gate_q;

  // updates only while clk_i is low; kill clears asynchronously
  always_ff @(negedge clk_i or negedge rst_ni or posedge kill_i) begin
    if (!rst_ni)     gate_q <= 1'b0;
    else if (kill_i) gate_q <= 1'b0;
    else             gate_q <= req_i;
  end

  assign gate_q_o = gate_q;
  assign clk_o    = clk_i & gate_q;
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 3,
  parameter int DRAIN_CYC   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] mode_i,
  output logic       clk_o,
  output logic       oe_o
);
  logic       en_s;
  logic       run_req;
  logic       kill;
  logic       settling;
  logic       draining;
  logic       ctrl_off;
  logic [1:0] mode_q;
  logic       gate_q;

  clkout_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en_i),
    .q_o    (en_s)
  );

  clkout_gate_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .DRAIN_CYC  (DRAIN_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_s_i     (en_s),
    .en_raw_i   (en_i),
    .mode_i     (mode_i),
    .run_req_o  (run_req),
    .oe_o       (oe_o),
    .kill_o     (kill),
    .settling_o (settling),
    .draining_o (draining),
    .off_o      (ctrl_off),
    .mode_q_o   (mode_q)
  );

  clkout_gate_cell u_cell (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kill_i   (kill),
    .req_i    (run_req),
    .gate_q_o (gate_q),
    .clk_o    (clk_o)
  );
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_req,
  input logic       gate_q,
  input logic       kill,
  input logic       settling,
  input logic       draining,
  input logic       ctrl_off,
  input logic       oe_o,
  input logic [1:0] mode_q
);
  p_gate_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_req |-> !gate_q);

  p_kill_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> !gate_q);

  p_settle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settling |-> !gate_q);

  p_float_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !gate_q);

  p_drain_runs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draining |-> run_req);

  p_mode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_off && !$past(ctrl_off)) |-> $stable(mode_q));
endmodule

bind clkout_gate clkout_gate_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_req  (run_req),
  .gate_q   (gate_q),
  .kill     (kill),
  .settling (settling),
  .draining (draining),
  .ctrl_off (ctrl_off),
  .oe_o     (oe_o),
  .mode_q   (mode_q)
);

// File: tb/tb_clkout_gate.sv
`timescale 1ns/100ps
module tb_clkout_gate;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [1:0] mode_i = 2'b01;
  logic       clk_o;
  logic       oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { string tag; int exp; int act; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  clkout_gate dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .clk_o  (clk_o),
    .oe_o   (oe_o)
  );

  // monitor: drains the scoreboard away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (it.act != it.exp) begin
          n_fail++;
          $display("FAIL %s: got %0d expected %0d", it.tag, it.act, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input int exp, input int act);
    item_t it;
    it.tag = tag; it.exp = exp; it.act = act;
    sb_q.push_back(it);
  endtask

  task automatic count_pulses(input int ncyc, output int n);
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #1;
      if (clk_o === 1'b1) n++;
    end
  endtask

  task automatic first_rise(output int k);
    k = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); #1;
      if (clk_o === 1'b1) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic idle(input int ncyc);
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, n2, k;
    // R9: reset state
    count_pulses(4, n);
    push("R9 pulses in reset", 0, n);
    push("R9 oe in reset", 1, int'(oe_o));

    // R6: settling after reset release, then R1 running
    @(negedge clk); rst_ni = 1'b1;
    first_rise(k);
    push("R6 first edge after reset", 7, k);
    count_pulses(20, n);
    push("R1 running pulses", 20, n);

    // R3: finish mode, drop at negedge
    @(negedge clk); en_i = 1'b0;
    count_pulses(50, n);
    push("R3 finish pulses", 3, n);
    count_pulses(20, n);
    push("R10 low while disabled", 0, n);

    // R6 wake-up, R3 drop mid-high
    @(negedge clk); en_i = 1'b1;
    first_rise(k);
    push("R6 first edge after enable", 7, k);
    idle(5);
    @(posedge clk); #1; en_i = 1'b0;
    #1;
    push("R3 high phase held", 1, int'(clk_o));
    count_pulses(30, n);
    push("R3 finish pulses mid-high", 3, n);

    // R2: immediate mode
    @(negedge clk); mode_i = 2'b00;
    idle(3);
    en_i = 1'b1;
    first_rise(k);
    idle(5);
    @(posedge clk); #1; en_i = 1'b0;
    #0.2;
    push("R2 immediate drop", 0, int'(clk_o));
    count_pulses(30, n);
    push("R2 no pulse after drop", 0, n);

    // R4: run-out mode
    @(negedge clk); mode_i = 2'b10;
    idle(3);
    en_i = 1'b1;
    first_rise(k);
    idle(5);
    @(negedge clk); en_i = 1'b0;
    count_pulses(60, n);
    push("R4 run-out pulses", 35, n);

    // R7: re-enable during run-out
    @(negedge clk); en_i = 1'b1;
    first_rise(k);
    idle(5);
    @(negedge clk); en_i = 1'b0;
    count_pulses(10, n);
    @(negedge clk); en_i = 1'b1;
    count_pulses(40, n2);
    push("R7 no gap on abort", 50, n + n2);
    @(negedge clk); en_i = 1'b0;
    count_pulses(60, n);
    push("R4 run-out after abort", 35, n);

    // R5: float mode
    @(negedge clk); mode_i = 2'b11;
    idle(3);
    push("R5 oe low while disabled", 0, int'(oe_o));
    en_i = 1'b1;
    count_pulses(5, n);
    push("R5 oe back on wake", 1, int'(oe_o));
    idle(15);
    @(negedge clk); en_i = 1'b0;
    count_pulses(10, n);
    push("R5 float stop pulses", 3, n);
    push("R5 oe released", 0, int'(oe_o));

    // R8: mode change while running ignored
    @(negedge clk); mode_i = 2'b01;
    idle(3);
    en_i = 1'b1;
    idle(20);
    mode_i = 2'b00;
    idle(5);
    @(posedge clk); #1; en_i = 1'b0;
    #1;
    push("R8 mode ignored mid-run", 1, int'(clk_o));
    count_pulses(30, n);
    push("R8 finish pulses kept", 3, n);

    // R9: reset in a high phase
    @(negedge clk); en_i = 1'b1;
    idle(20);
    @(posedge clk); #1; rst_ni = 1'b0;
    #0.2;
    push("R9 reset drops clk_o", 0, int'(clk_o));
    push("R9 oe during reset", 1, int'(oe_o));

    idle(2);
    done = 1'b1;
    finish_run();
  end
endmodule